// File: doc/BRIEF.md
# Digital Potentiometer Command Executor

This block carries out the instructions of a quad digital potentiometer once a separate serial bus engine has framed them. It holds four volatile 8-bit wiper registers and sixteen 8-bit data registers, four for each pot. The data registers model nonvolatile storage: they are flops, and a store timer guards every write to them. The bus engine passes in the events it has framed: an instruction byte, a data byte, an increment or decrement step, and a stop. The block returns the byte to shift out for reads, and a busy flag. The bus engine uses busy to withhold its acknowledge, so a host can poll for the end of a store.

The instruction byte holds an opcode in bits 7:4, a data register select in bits 3:2 and a pot select in bits 1:0. The controller is one state machine with these states:

- `ST_RECALL` copies data register 0 of each pot into its wiper on the first clock after reset, then moves to `ST_IDLE`.
- `ST_IDLE` decodes an instruction. A read latches its byte and moves to `ST_HOLD`. A wiper or data write moves to `ST_GET_DATA`. An increment/decrement moves to `ST_STEP`. A wiper-to-data transfer moves to `ST_ARMED`, or to `ST_HOLD` when write-protected. A data-to-wiper transfer executes at once and moves to `ST_HOLD`. An undefined opcode moves to `ST_HOLD`.
- `ST_GET_DATA` takes the data byte. A wiper write goes to `ST_HOLD`. An unprotected data write goes to `ST_ARMED`. A protected data write goes to `ST_HOLD`. A stop here abandons the write and returns to `ST_IDLE`.
- `ST_HOLD` and `ST_STEP` return to `ST_IDLE` on stop.
- `ST_ARMED` commits the store on stop and moves to `ST_STORE`.
- `ST_STORE` returns to `ST_IDLE` when the timer expires.

Top module: `digipot_cmd_exec`

## Requirements
- R1: Busy reads 1 and every wiper reads 0 while reset is held. On the first clock after reset is released, each wiper loads its pot's data register 0, and busy falls. The data register r of pot p resets to (DR_SEED + 17*(4p+r)) mod 256, with DR_SEED = 5 by default.
- R2: In the instruction byte, bits 7:4 are the opcode, bits 3:2 the data register and bits 1:0 the pot. The opcodes are: 1001 read wiper, 1010 write wiper, 1011 read data register, 1100 write data register, 1101 data register to wiper, 1110 wiper to data register, 0001 global data register to wipers, 1000 global wipers to data registers, 0010 increment/decrement.
- R3: A write-wiper instruction loads the following data byte into the addressed wiper on the clock that accepts the byte.
- R4: A read instruction places the addressed wiper or data register on rd_data on the clock that accepts the instruction.
- R5: A data-register-to-wiper transfer loads the selected register into the addressed wiper immediately. The global form does this for all four pots with the same register select. A global instruction whose pot field is not 00 is ignored.
- R6: A data register write, a wiper-to-data transfer and the global wiper-to-data transfer are committed on the clock that accepts the stop. Busy is then 1 for exactly STORE_CYCLES cycles.
- R7: While a store is busy, every instruction, data byte and step is ignored.
- R8: With wp_n low, stores leave the data registers unchanged and do not raise busy. Wiper writes still take effect.
- R9: An opcode outside the nine defined ones changes no register, and the bytes after it up to the stop are ignored.
- R10: Each increment or decrement step moves the addressed wiper by one. The wiper holds at 255 going up and at 0 going down.
- R11: A stop that arrives before the data byte of a write abandons the write. A data byte outside a write is ignored.
- R12: Busy stays 0 between the data byte of a store and its stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| wp_n | input | 1 | Low blocks stores to the data registers |
| cmd_valid | input | 1 | Instruction byte present this cycle |
| cmd_byte | input | 8 | Instruction byte |
| data_valid | input | 1 | Data byte present this cycle |
| data_byte | input | DW | Data byte from the host |
| step_valid | input | 1 | One increment/decrement step this cycle |
| step_up | input | 1 | Step direction, 1 = up |
| stop_seen | input | 1 | Stop condition framed this cycle |
| rd_data | output | DW | Byte to send back for a read |
| busy | output | 1 | Recall or store in progress |
| wiper | output | NPOT*DW | Wiper registers, pot p at bits p*DW +: DW |

## Verification
The assertions take it for granted that the bus engine raises at most one of cmd_valid, data_valid, step_valid and stop_seen in a cycle. They also assume each event lasts exactly one clock, and that the pot field stays steady while a step is applied. The stimulus drives every event as a single-cycle pulse from a task that changes the inputs on the falling edge. It never overlaps two events, and it changes wp_n only between transactions.

// File: rtl/digipot_pkg.sv
package digipot_pkg;

    localparam int unsigned INSN_W = 8;
    localparam int unsigned OPC_W  = 4;

    localparam logic [OPC_W-1:0] OPC_GXFR_D2W = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_INCDEC   = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_GXFR_W2D = 4'b1000;
    localparam logic [OPC_W-1:0] OPC_RD_WCR   = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_WR_WCR   = 4'b1010;
    localparam logic [OPC_W-1:0] OPC_RD_DR    = 4'b1011;
    localparam logic [OPC_W-1:0] OPC_WR_DR    = 4'b1100;
    localparam logic [OPC_W-1:0] OPC_XFR_D2W  = 4'b1101;
    localparam logic [OPC_W-1:0] OPC_XFR_W2D  = 4'b1110;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_RD_WCR,
        OP_WR_WCR,
        OP_RD_DR,
        OP_WR_DR,
        OP_XFR_D2W,
        OP_XFR_W2D,
        OP_GXFR_D2W,
        OP_GXFR_W2D,
        OP_INCDEC
    } op_e;

    typedef enum logic [2:0] {
        ST_RECALL,
        ST_IDLE,
        ST_GET_DATA,
        ST_HOLD,
        ST_STEP,
        ST_ARMED,
        ST_STORE
    } state_e;

endpackage

// File: rtl/digipot_decode.sv
module digipot_decode
    import digipot_pkg::*;
#(
    parameter int unsigned POT_W = 2,
    parameter int unsigned REG_W = 2
) (
    input  logic [INSN_W-1:0] insn,
    output op_e               op,
    output logic [REG_W-1:0]  rsel,
    output logic [POT_W-1:0]  psel
);

    localparam int unsigned OPC_LSB = INSN_W - OPC_W;

    logic [OPC_W-1:0] opc;
    logic             pot_zero;

    assign opc      = insn[INSN_W-1:OPC_LSB];
    assign psel     = insn[POT_W-1:0];
    assign rsel     = insn[POT_W+REG_W-1:POT_W];
    assign pot_zero = (psel == '0);

    always_comb begin
        case (opc)
            OPC_RD_WCR:   op = OP_RD_WCR;
            OPC_WR_WCR:   op = OP_WR_WCR;
            OPC_RD_DR:    op = OP_RD_DR;
            OPC_WR_DR:    op = OP_WR_DR;
            OPC_XFR_D2W:  op = OP_XFR_D2W;
            OPC_XFR_W2D:  op = OP_XFR_W2D;
            OPC_GXFR_D2W: op = pot_zero ? OP_GXFR_D2W : OP_NONE; // R5 pot field must be 00
            OPC_GXFR_W2D: op = pot_zero ? OP_GXFR_W2D : OP_NONE;
            OPC_INCDEC:   op = OP_INCDEC;
            default:      op = OP_NONE;                           // R9
        endcase
    end

endmodule

// File: rtl/digipot_store_timer.sv
module digipot_store_timer #(
    parameter int unsigned CYCLES = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire,
    output logic active
);

    localparam int unsigned CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);
    assign expire = (cnt_q == CNT_W'(1));

    a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CYCLES));

    a_r6_start_loads_full: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == CNT_W'(CYCLES)));

endmodule

// File: rtl/digipot_regfile.sv
module digipot_regfile #(
    parameter int unsigned NPOT    = 4,
    parameter int unsigned NREG    = 4,
    parameter int unsigned DW      = 8,
    parameter int unsigned DR_SEED = 5,
    localparam int unsigned REG_W  = $clog2(NREG)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NPOT-1:0]                  wcr_we,
    input  logic [NPOT-1:0][DW-1:0]          wcr_wd,
    input  logic [NPOT-1:0]                  dr_we,
    input  logic [REG_W-1:0]                 dr_sel,
    input  logic [NPOT-1:0][DW-1:0]          dr_wd,
    output logic [NPOT-1:0][DW-1:0]          wcr_q,
    output logic [NPOT-1:0][NREG-1:0][DW-1:0] dr_q
);

    function automatic logic [DW-1:0] dr_init(input int unsigned p, input int unsigned r);
        int unsigned v;
        v = DR_SEED + 17 * (p * NREG + r);
        return DW'(v);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPOT; p++) begin
                wcr_q[p] <= '0;
            end
        end else begin
            for (int p = 0; p < NPOT; p++) begin
                if (wcr_we[p]) begin
                    wcr_q[p] <= wcr_wd[p];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPOT; p++) begin
                for (int r = 0; r < NREG; r++) begin
                    dr_q[p][r] <= dr_init(p, r);
                end
            end
        end else begin
            for (int p = 0; p < NPOT; p++) begin
                for (int r = 0; r < NREG; r++) begin
                    if (dr_we[p] && (dr_sel == REG_W'(r))) begin
                        dr_q[p][r] <= dr_wd[p];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/digipot_cmd_exec.sv
module digipot_cmd_exec
    import digipot_pkg::*;
#(
    parameter int unsigned NPOT         = 4,
    parameter int unsigned NREG         = 4,
    parameter int unsigned DW           = 8,
    parameter int unsigned STORE_CYCLES = 2500000,
    parameter int unsigned DR_SEED      = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wp_n,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_byte,
    input  logic                 data_valid,
    input  logic [DW-1:0]        data_byte,
    input  logic                 step_valid,
    input  logic                 step_up,
    input  logic                 stop_seen,
    output logic [DW-1:0]        rd_data,
    output logic                 busy,
    output logic [NPOT*DW-1:0]   wiper
);

    localparam int unsigned POT_W = $clog2(NPOT);
    localparam int unsigned REG_W = $clog2(NREG);
    localparam logic [DW-1:0] WMAX = {DW{1'b1}};

    // ---------------- state and held command fields ----------------
    state_e             st_q, st_d;
    op_e                op_q, op_d;
    logic [REG_W-1:0]   reg_q, reg_d;
    logic [POT_W-1:0]   pot_q, pot_d;
    logic [DW-1:0]      dat_q, dat_d;
    logic [DW-1:0]      rd_q, rd_d;
    logic               tmr_start;
    logic               tmr_expire;
    logic               tmr_active;

    op_e                dec_op;
    logic [REG_W-1:0]   dec_reg;
    logic [POT_W-1:0]   dec_pot;

    logic [NPOT-1:0]                  wcr_we;
    logic [NPOT-1:0][DW-1:0]          wcr_wd;
    logic [NPOT-1:0]                  dr_we;
    logic [REG_W-1:0]                 dr_sel;
    logic [NPOT-1:0][DW-1:0]          dr_wd;
    logic [NPOT-1:0][DW-1:0]          wcr_q;
    logic [NPOT-1:0][NREG-1:0][DW-1:0] dr_q;
    logic [DW-1:0]                    step_cur;

    digipot_decode #(
        .POT_W (POT_W),
        .REG_W (REG_W)
    ) u_decode (
        .insn (cmd_byte),
        .op   (dec_op),
        .rsel (dec_reg),
        .psel (dec_pot)
    );

    digipot_store_timer #(
        .CYCLES (STORE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .expire (tmr_expire),
        .active (tmr_active)
    );

    digipot_regfile #(
        .NPOT    (NPOT),
        .NREG    (NREG),
        .DW      (DW),
        .DR_SEED (DR_SEED)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wcr_we (wcr_we),
        .wcr_wd (wcr_wd),
        .dr_we  (dr_we),
        .dr_sel (dr_sel),
        .dr_wd  (dr_wd),
        .wcr_q  (wcr_q),
        .dr_q   (dr_q)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RECALL;
            op_q  <= OP_NONE;
            reg_q <= '0;
            pot_q <= '0;
            dat_q <= '0;
            rd_q  <= '0;
        end else begin
            st_q  <= st_d;
            op_q  <= op_d;
            reg_q <= reg_d;
            pot_q <= pot_d;
            dat_q <= dat_d;
            rd_q  <= rd_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d      = st_q;
        op_d      = op_q;
        reg_d     = reg_q;
        pot_d     = pot_q;
        dat_d     = dat_q;
        rd_d      = rd_q;
        tmr_start = 1'b0;
        unique case (st_q)
            ST_RECALL: st_d = ST_IDLE;
            ST_IDLE: begin
                if (cmd_valid) begin
                    op_d  = dec_op;
                    reg_d = dec_reg;
                    pot_d = dec_pot;
                    case (dec_op)
                        OP_RD_WCR: begin
                            rd_d = wcr_q[dec_pot];
                            st_d = ST_HOLD;
                        end
                        OP_RD_DR: begin
                            rd_d = dr_q[dec_pot][dec_reg];
                            st_d = ST_HOLD;
                        end
                        OP_WR_WCR, OP_WR_DR:       st_d = ST_GET_DATA;
                        OP_XFR_W2D, OP_GXFR_W2D:   st_d = wp_n ? ST_ARMED : ST_HOLD;
                        OP_INCDEC:                 st_d = ST_STEP;
                        default:                   st_d = ST_HOLD;
                    endcase
                end
            end
            ST_GET_DATA: begin
                if (stop_seen) begin
                    st_d = ST_IDLE;
                end else if (data_valid) begin
                    dat_d = data_byte;
                    st_d  = ((op_q == OP_WR_DR) && wp_n) ? ST_ARMED : ST_HOLD;
                end
            end
            ST_HOLD, ST_STEP: begin
                if (stop_seen) st_d = ST_IDLE;
            end
            ST_ARMED: begin
                if (stop_seen) begin
                    st_d      = ST_STORE;
                    tmr_start = 1'b1;
                end
            end
            ST_STORE: begin
                if (tmr_expire) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // ---------------- register file controls ----------------
    assign step_cur = wcr_q[pot_q];

    always_comb begin
        wcr_we = '0;
        dr_we  = '0;
        dr_sel = reg_q;
        for (int p = 0; p < NPOT; p++) begin
            wcr_wd[p] = dr_q[p][0];
            dr_wd[p]  = wcr_q[p];
        end
        unique case (st_q)
            ST_RECALL: wcr_we = '1;
            ST_IDLE: begin
                if (cmd_valid && (dec_op == OP_XFR_D2W)) begin
                    wcr_we[dec_pot] = 1'b1;
                    wcr_wd[dec_pot] = dr_q[dec_pot][dec_reg];
                end else if (cmd_valid && (dec_op == OP_GXFR_D2W)) begin
                    wcr_we = '1;
                    for (int p = 0; p < NPOT; p++) wcr_wd[p] = dr_q[p][dec_reg];
                end
            end
            ST_GET_DATA: begin
                if (!stop_seen && data_valid && (op_q == OP_WR_WCR)) begin
                    wcr_we[pot_q] = 1'b1;
                    wcr_wd[pot_q] = data_byte;
                end
            end
            ST_STEP: begin
                if (!stop_seen && step_valid) begin
                    wcr_we[pot_q] = 1'b1;
                    if (step_up) wcr_wd[pot_q] = (step_cur == WMAX) ? step_cur : step_cur + 1'b1;
                    else         wcr_wd[pot_q] = (step_cur == '0)   ? step_cur : step_cur - 1'b1;
                end
            end
            ST_ARMED: begin
                if (stop_seen) begin
                    if (op_q == OP_GXFR_W2D) begin
                        dr_we = '1;
                    end else begin
                        dr_we[pot_q] = 1'b1;
                        if (op_q == OP_WR_DR) dr_wd[pot_q] = dat_q;
                    end
                end
            end
            ST_HOLD, ST_STORE: ;
            default: ;
        endcase
    end

    // ---------------- outputs ----------------
    assign rd_data = rd_q;
    assign busy    = (st_q == ST_RECALL) || (st_q == ST_STORE);
    assign wiper   = wcr_q;

    // ---------------- assertions ----------------
    for (genvar g = 0; g < NPOT; g++) begin : g_recall_chk
        a_r1_recall_dr0: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == ST_RECALL) |=> (wcr_q[g] == $past(dr_q[g][0])));
    end

    a_r12_busy_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_seen));

    a_r6_store_has_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STORE) |-> tmr_active);

    a_r7_store_keeps_wipers: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_STORE) && ($past(st_q) == ST_STORE)) |-> $stable(wcr_q));

    a_r8_protect_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && cmd_valid && !wp_n &&
         ((dec_op == OP_XFR_W2D) || (dec_op == OP_GXFR_W2D))) |=> (st_q != ST_ARMED));

    a_r10_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_STEP) && step_valid && step_up && !stop_seen && (step_cur == WMAX))
        |=> (wcr_q[pot_q] == WMAX));

    a_r10_hold_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_STEP) && step_valid && !step_up && !stop_seen && (step_cur == '0))
        |=> (wcr_q[pot_q] == '0));

endmodule

// File: tb/digipot_cmd_exec_tb.sv
module digipot_cmd_exec_tb;

    localparam int unsigned STORE = 20;
    localparam int NV = 14;

    // {skip, cmd[8], usedat, dat[8], kind(0 wiper,1 rd), pot[2], exp[8], req[4]}
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'hA1, 1'b1, 8'h3C, 1'b0, 2'd1, 8'h3C, 4'd3},  // R3 write wiper 1
        {1'b0, 8'h91, 1'b0, 8'h00, 1'b1, 2'd0, 8'h3C, 4'd4},  // R4 read wiper 1
        {1'b0, 8'hB2, 1'b0, 8'h00, 1'b1, 2'd0, 8'h8D, 4'd4},  // R4 read DR p2 r0
        {1'b0, 8'hBF, 1'b0, 8'h00, 1'b1, 2'd0, 8'h04, 4'd2},  // R2 fields p3 r3
        {1'b0, 8'hDB, 1'b0, 8'h00, 1'b0, 2'd3, 8'hF3, 4'd5},  // R5 DR p3 r2 -> wiper3
        {1'b0, 8'h14, 1'b0, 8'h00, 1'b0, 2'd0, 8'h16, 4'd5},  // R5 global r1
        {1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 2'd1, 8'h5A, 4'd5},
        {1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 2'd2, 8'h9E, 4'd5},
        {1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 2'd3, 8'hE2, 4'd5},
        {1'b0, 8'h19, 1'b0, 8'h00, 1'b0, 2'd0, 8'h16, 4'd5},  // R5 global pot!=0 ignored
        {1'b0, 8'h71, 1'b1, 8'h99, 1'b0, 2'd1, 8'h5A, 4'd9},  // R9 undefined opcode
        {1'b0, 8'h01, 1'b1, 8'h33, 1'b0, 2'd1, 8'h5A, 4'd9},  // R9 opcode 0000
        {1'b0, 8'hA2, 1'b1, 8'h00, 1'b0, 2'd2, 8'h00, 4'd3},  // R3 write zero
        {1'b0, 8'h92, 1'b0, 8'h00, 1'b1, 2'd0, 8'h00, 4'd4}   // R4 read back
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_n = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        data_valid = 1'b0;
    logic [7:0]  data_byte = '0;
    logic        step_valid = 1'b0;
    logic        step_up = 1'b0;
    logic        stop_seen = 1'b0;
    logic [7:0]  rd_data;
    logic        busy;
    logic [31:0] wiper;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    digipot_cmd_exec #(.STORE_CYCLES(STORE)) u_dut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .data_valid(data_valid), .data_byte(data_byte),
        .step_valid(step_valid), .step_up(step_up), .stop_seen(stop_seen),
        .rd_data(rd_data), .busy(busy), .wiper(wiper)
    );

    function automatic logic [7:0] wp_of(input int p);
        return wiper[p*8 +: 8];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic send_data(input logic [7:0] b);
        @(negedge clk); data_valid = 1'b1; data_byte = b;
        @(negedge clk); data_valid = 1'b0;
    endtask

    task automatic send_stop();
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
    endtask

    task automatic send_step(input logic up);
        @(negedge clk); step_valid = 1'b1; step_up = up;
        @(negedge clk); step_valid = 1'b0;
    endtask

    task automatic txn(input logic [7:0] c, input logic ud, input logic [7:0] d);
        send_cmd(c);
        if (ud) send_data(d);
        send_stop();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    // counts busy cycles starting at the negedge right after the stop
    task automatic count_busy(output int n);
        n = 0;
        for (int i = 0; i < 1000 && busy; i++) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        logic [32:0] v;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 32'(busy), 32'd1);
        check("R1 wipers zero in reset", wiper, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 recall DR0", wiper, 32'hD18D4905);
        check("R1 busy low after recall", 32'(busy), 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            if (!v[32]) txn(v[31:24], v[23], v[22:15]);
            if (v[14]) check($sformatf("R%0d vector %0d rd_data", v[3:0], i), 32'(rd_data), 32'(v[11:4]));
            else       check($sformatf("R%0d vector %0d wiper", v[3:0], i), 32'(wp_of(int'(v[13:12]))), 32'(v[11:4]));
        end

        // R12 / R6 data register store
        send_cmd(8'hC6);
        send_data(8'h77);
        check("R12 no busy before stop", 32'(busy), 32'd0);
        repeat (3) @(negedge clk);
        check("R12 still no busy waiting stop", 32'(busy), 32'd0);
        send_stop();
        count_busy(n);
        check("R6 busy length", 32'(n), 32'(STORE));
        txn(8'hB6, 1'b0, 8'h00);
        check("R6 DR p2 r1 stored", 32'(rd_data), 32'h77);

        // R7 commands ignored while busy
        txn(8'hC8, 1'b1, 8'h44);
        check("R7 busy after store", 32'(busy), 32'd1);
        txn(8'hA0, 1'b1, 8'hAA);
        wait_idle();
        check("R7 wiper0 untouched during busy", 32'(wp_of(0)), 32'h16);
        txn(8'hB8, 1'b0, 8'h00);
        check("R7 first store landed", 32'(rd_data), 32'h44);

        // R8 write protect
        wp_n = 1'b0;
        txn(8'hC7, 1'b1, 8'h11);
        check("R8 protected write no busy", 32'(busy), 32'd0);
        txn(8'hE7, 1'b0, 8'h00);
        check("R8 protected transfer no busy", 32'(busy), 32'd0);
        txn(8'hB7, 1'b0, 8'h00);
        check("R8 DR p3 r1 unchanged", 32'(rd_data), 32'hE2);
        txn(8'hA3, 1'b1, 8'h55);
        check("R8 wiper write still works", 32'(wp_of(3)), 32'h55);
        wp_n = 1'b1;

        // R6 wiper to data register
        txn(8'hEC, 1'b0, 8'h00);
        count_busy(n);
        check("R6 transfer busy length", 32'(n), 32'(STORE));
        txn(8'hBC, 1'b0, 8'h00);
        check("R6 DR p0 r3 from wiper", 32'(rd_data), 32'h16);

        // R6 global wipers to data registers
        txn(8'h88, 1'b0, 8'h00);
        wait_idle();
        txn(8'hBB, 1'b0, 8'h00);
        check("R6 global DR p3 r2", 32'(rd_data), 32'h55);
        txn(8'hB8, 1'b0, 8'h00);
        check("R6 global DR p0 r2", 32'(rd_data), 32'h16);

        // R10 increment / decrement with saturation
        txn(8'hA1, 1'b1, 8'hFE);
        send_cmd(8'h21);
        send_step(1'b1);
        check("R10 step up", 32'(wp_of(1)), 32'hFF);
        send_step(1'b1);
        send_step(1'b1);
        check("R10 hold at top", 32'(wp_of(1)), 32'hFF);
        send_step(1'b0);
        send_step(1'b0);
        check("R10 step down", 32'(wp_of(1)), 32'hFD);
        send_stop();
        txn(8'hA0, 1'b1, 8'h01);
        send_cmd(8'h20);
        send_step(1'b0);
        send_step(1'b0);
        send_step(1'b0);
        check("R10 hold at bottom", 32'(wp_of(0)), 32'h00);
        send_step(1'b1);
        check("R10 up from bottom", 32'(wp_of(0)), 32'h01);
        send_stop();

        // R11 stop before data abandons write
        send_cmd(8'hA3);
        send_stop();
        send_data(8'hEE);
        check("R11 abandoned write", 32'(wp_of(3)), 32'h55);
        check("R11 no busy", 32'(busy), 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule